// File: doc/BRIEF.md
# Prefix Window Comparator Array

This block is the front stage of a multi-pattern text scanner. Each clock cycle it takes a beat of several 8-bit characters and builds one candidate window per lane. The window for a lane is the run of prefix-length characters that ends on that lane. Every window is compared at once against the short prefixes of all stored patterns. The result is a pattern-by-lane hit matrix. It is registered so that a downstream resolver can pick which pattern body to verify next.

The block keeps the tail of the previous beat, so a window that straddles two beats is compared as one contiguous run of text. A window that would reach back before the start of the text is suppressed. Such a window occurs in the first beat after reset or after an end-of-text beat.

A downstream stall freezes the block. It stops taking beats, the history stays as it is, and the registered matrix holds its value. Prefixes are written one pattern at a time through a small write port, normally while no text is flowing.

Top module: `prefix_window_matcher`

## Requirements
- R1: During and right after reset, `out_valid` and `out_last` are 0, every `out_match` bit is 0, and `in_ready` is 1 while `stall` is 0.
- R2: A write with `wr_en`=1 stores `wr_prefix` as the prefix of pattern `wr_idx`. Byte 0 (bits 7:0) is the first character. A pattern that has not been written since reset never raises a match bit, even when the text equals its cleared value of all zero bytes.
- R3: Lane 0 of `in_data` (bits 7:0) is the earliest character of a beat. Bit `p*LANES+i` of `out_match` is 1 exactly when the prefix-length characters that end on lane i equal the prefix of pattern p, and every one of those characters is inside the current text.
- R4: Windows that end on a lane below prefix-length minus one take their leading characters from the final characters of the previous accepted beat. Beats that were not accepted, and cycles without a valid beat, are skipped over and are not part of the text.
- R5: In the first accepted beat of a text, the windows that end on lanes 0 to prefix-length minus two report 0 for every pattern, whatever the history register holds.
- R6: An accepted beat with `in_last`=1 ends the text. It is still matched in full, `out_last` rises with its result, and the next accepted beat starts a new text (see R5).
- R7: The result for a beat accepted at a rising edge is on `out_valid`/`out_match` right after that edge. An unstalled cycle with `in_valid`=0 gives `out_valid`=0 and an all-zero matrix.
- R8: `in_ready` equals the inverse of `stall`. While `stall` is 1 no beat is taken, the window history is unchanged, and `out_valid`, `out_last` and `out_match` hold their values.
- R9: Several patterns, including two with the same prefix, can match the same window in the same beat, and each raises its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Prefix write strobe |
| wr_idx | input | clog2(NUM_PAT) | Pattern slot being written |
| wr_prefix | input | PFX_LEN*8 | Prefix characters, byte 0 first |
| in_valid | input | 1 | Beat on `in_data` carries text |
| in_last | input | 1 | Beat is the final one of the text |
| in_data | input | LANES*8 | Text beat, lane 0 in bits 7:0 |
| in_ready | output | 1 | Block takes a beat this cycle |
| stall | input | 1 | Downstream hold request |
| out_valid | output | 1 | Registered matrix belongs to a text beat |
| out_last | output | 1 | Registered matrix belongs to the final beat |
| out_match | output | NUM_PAT*LANES | Hit matrix, bit p*LANES+i is pattern p at lane i |

## Verification
The patterns are chosen so that each kind of hit can be told apart. Some windows lie fully inside one beat and some straddle a beat boundary. Two patterns share one prefix, and one prefix repeats within the window range so that several lanes of the same row fire together. A beat right after an end-of-text beat starts with characters that would complete a prefix from the old history, which separates correct masking from stale history. An invalid beat and a stalled beat carry data that would create a false cross-beat hit if either one leaked into the history. An all-zero beat and a reset in mid-run show whether unwritten or cleared pattern slots stay silent.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int CHAR_W      = 8;
    localparam int DEF_LANES   = 8;
    localparam int DEF_PFX_LEN = 4;
    localparam int DEF_NUM_PAT = 16;

    typedef logic [CHAR_W-1:0] char_t;

    // characters carried over from the previous beat
    function automatic int hist_depth(input int pfx_len);
        return (pfx_len > 1) ? pfx_len - 1 : 1;
    endfunction

    // bits needed to count 0..maxv
    function automatic int count_bits(input int maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

    // bits needed to address n slots
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pwm_window_builder.sv
module pwm_window_builder
    import pwm_pkg::*;
#(
    parameter int LANES   = DEF_LANES,
    parameter int PFX_LEN = DEF_PFX_LEN
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              advance,
    input  logic                              beat_last,
    input  char_t [LANES-1:0]                 beat,
    output char_t [LANES-1:0][PFX_LEN-1:0]    win,
    output logic  [LANES-1:0]                 win_ok
);
    localparam int HIST  = hist_depth(PFX_LEN);
    localparam int EXT   = LANES + HIST;
    localparam int CNT_W = count_bits(HIST);

    char_t [HIST-1:0]  hist;
    logic  [CNT_W-1:0] hist_cnt;
    char_t [EXT-1:0]   ext;

    // extended text: carried tail first, then the new beat
    always_comb begin
        for (int h = 0; h < HIST; h++) ext[h] = hist[h];
        for (int j = 0; j < LANES; j++) ext[HIST+j] = beat[j];
    end

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            for (genvar c = 0; c < PFX_LEN; c++) begin : g_chr
                assign win[i][c] = ext[i+c];
            end
            if (i >= HIST) begin : g_full
                assign win_ok[i] = 1'b1;
            end else begin : g_edge
                // needs HIST-i characters of real history
                assign win_ok[i] = (int'(hist_cnt) >= (HIST - i));
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist     <= '0;
            hist_cnt <= '0;
        end else if (advance) begin
            for (int h = 0; h < HIST; h++) hist[h] <= ext[LANES+h];
            if (beat_last)
                hist_cnt <= '0;
            else if (int'(hist_cnt) + LANES >= HIST)
                hist_cnt <= CNT_W'(HIST);
            else
                hist_cnt <= CNT_W'(int'(hist_cnt) + LANES);
        end
    end

    // R8: history untouched when no beat is taken
    p_hist_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!rst && !advance) |=> ($stable(hist) && $stable(hist_cnt)));

    // R6: end of text forgets the history
    p_last_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (!rst && advance && beat_last) |=> (hist_cnt == '0));

    // R5: count of remembered characters stays within the carried depth
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        int'(hist_cnt) <= HIST);
endmodule

// File: rtl/pwm_prefix_store.sv
module pwm_prefix_store
    import pwm_pkg::*;
#(
    parameter int NUM_PAT = DEF_NUM_PAT,
    parameter int PFX_LEN = DEF_PFX_LEN
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [idx_bits(NUM_PAT)-1:0]        wr_idx,
    input  char_t [PFX_LEN-1:0]                 wr_prefix,
    output char_t [NUM_PAT-1:0][PFX_LEN-1:0]    pfx,
    output logic  [NUM_PAT-1:0]                 pfx_ok
);
    localparam int IDX_W = idx_bits(NUM_PAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            pfx    <= '0;
            pfx_ok <= '0;
        end else if (wr_en) begin
            for (int p = 0; p < NUM_PAT; p++) begin
                if (wr_idx == IDX_W'(p)) begin
                    pfx[p]    <= wr_prefix;
                    pfx_ok[p] <= 1'b1;
                end
            end
        end
    end

    // R2: a write to an existing slot arms that slot
    p_write_arms_r2: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_en && (int'(wr_idx) < NUM_PAT)) |=> pfx_ok[$past(wr_idx)]);
endmodule

// File: rtl/pwm_compare_array.sv
module pwm_compare_array
    import pwm_pkg::*;
#(
    parameter int NUM_PAT = DEF_NUM_PAT,
    parameter int LANES   = DEF_LANES,
    parameter int PFX_LEN = DEF_PFX_LEN
) (
    input  char_t [NUM_PAT-1:0][PFX_LEN-1:0]  pfx,
    input  logic  [NUM_PAT-1:0]               pfx_ok,
    input  char_t [LANES-1:0][PFX_LEN-1:0]    win,
    input  logic  [LANES-1:0]                 win_ok,
    output logic  [NUM_PAT*LANES-1:0]         hit
);
    generate
        for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
            for (genvar i = 0; i < LANES; i++) begin : g_win
                assign hit[p*LANES+i] = pfx_ok[p] & win_ok[i] & (win[i] == pfx[p]);
            end
        end
    endgenerate
endmodule

// File: rtl/prefix_window_matcher.sv
module prefix_window_matcher
    import pwm_pkg::*;
#(
    parameter int LANES   = DEF_LANES,
    parameter int PFX_LEN = DEF_PFX_LEN,
    parameter int NUM_PAT = DEF_NUM_PAT
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [idx_bits(NUM_PAT)-1:0]     wr_idx,
    input  logic [PFX_LEN*CHAR_W-1:0]        wr_prefix,
    input  logic                             in_valid,
    input  logic                             in_last,
    input  logic [LANES*CHAR_W-1:0]          in_data,
    output logic                             in_ready,
    input  logic                             stall,
    output logic                             out_valid,
    output logic                             out_last,
    output logic [NUM_PAT*LANES-1:0]         out_match
);
    localparam int CELLS = NUM_PAT * LANES;

    char_t [LANES-1:0]                  beat;
    char_t [PFX_LEN-1:0]                wr_chars;
    char_t [LANES-1:0][PFX_LEN-1:0]     win;
    logic  [LANES-1:0]                  win_ok;
    char_t [NUM_PAT-1:0][PFX_LEN-1:0]   pfx;
    logic  [NUM_PAT-1:0]                pfx_ok;
    logic  [CELLS-1:0]                  hit;
    logic                               accept;

    assign beat     = in_data;
    assign wr_chars = wr_prefix;
    assign in_ready = ~stall;
    assign accept   = in_valid & in_ready;

    pwm_prefix_store #(.NUM_PAT(NUM_PAT), .PFX_LEN(PFX_LEN)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_prefix(wr_chars), .pfx(pfx), .pfx_ok(pfx_ok)
    );

    pwm_window_builder #(.LANES(LANES), .PFX_LEN(PFX_LEN)) u_win (
        .clk(clk), .rst(rst), .advance(accept), .beat_last(in_last),
        .beat(beat), .win(win), .win_ok(win_ok)
    );

    pwm_compare_array #(.NUM_PAT(NUM_PAT), .LANES(LANES), .PFX_LEN(PFX_LEN)) u_cmp (
        .pfx(pfx), .pfx_ok(pfx_ok), .win(win), .win_ok(win_ok), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_match <= '0;
        end else if (!stall) begin
            out_valid <= in_valid;
            out_last  <= in_valid & in_last;
            out_match <= in_valid ? hit : '0;
        end
    end

    // R8: registered matrix frozen while downstream holds
    p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (!rst && stall) |=> ($stable(out_match) && $stable(out_valid) && $stable(out_last)));

    // R7: no hit without a valid beat behind it
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_match == '0));

    // R6: end marker only accompanies a valid result
    p_last_valid_r6: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);
endmodule

// File: tb/prefix_window_matcher_tb.sv
module prefix_window_matcher_tb;
    localparam int M = 8;
    localparam int K = 4;
    localparam int N = 16;
    localparam int H = K - 1;

    typedef struct packed {
        logic [63:0] txt;   // first character in the top byte
        logic        vld;
        logic        lst;
        logic [15:0] tag;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{txt: "abcdefgh", vld: 1'b1, lst: 1'b0, tag: "R5"},
        '{txt: "ijxxabcd", vld: 1'b1, lst: 1'b0, tag: "R4"},
        '{txt: "efhhhhhh", vld: 1'b1, lst: 1'b1, tag: "R6"},
        '{txt: "hcdefabc", vld: 1'b1, lst: 1'b0, tag: "R5"},
        '{txt: "abcdabcd", vld: 1'b0, lst: 1'b0, tag: "R7"},
        '{txt: "dxyzghij", vld: 1'b1, lst: 1'b0, tag: "R4"},
        '{txt: 64'h0,      vld: 1'b1, lst: 1'b0, tag: "R2"}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_idx = '0;
    logic [K*8-1:0] wr_prefix = '0;
    logic           in_valid = 1'b0;
    logic           in_last = 1'b0;
    logic [M*8-1:0] in_data = '0;
    logic           in_ready;
    logic           stall = 1'b0;
    logic           out_valid;
    logic           out_last;
    logic [N*M-1:0] out_match;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_pfx [N][K];
    bit         m_ok  [N];
    logic [7:0] m_hist [H];
    int         m_cnt = 0;
    logic [N*M-1:0] last_exp = '0;

    always #2 clk = ~clk;

    prefix_window_matcher u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_prefix(wr_prefix),
        .in_valid(in_valid), .in_last(in_last), .in_data(in_data), .in_ready(in_ready),
        .stall(stall), .out_valid(out_valid), .out_last(out_last), .out_match(out_match)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [N*M-1:0] act, input logic [N*M-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [M*8-1:0] to_lanes(input logic [63:0] s);
        logic [M*8-1:0] r;
        for (int j = 0; j < M; j++) r[8*j +: 8] = s[63-8*j -: 8];
        return r;
    endfunction

    function automatic logic [N*M-1:0] model_expect(input logic [63:0] s);
        logic [7:0] ext [H+M];
        logic [N*M-1:0] r = '0;
        for (int h = 0; h < H; h++) ext[h] = m_hist[h];
        for (int j = 0; j < M; j++) ext[H+j] = s[63-8*j -: 8];
        for (int p = 0; p < N; p++) begin
            for (int i = 0; i < M; i++) begin
                bit eq = m_ok[p] && ((i >= H) || (m_cnt >= H - i));
                for (int c = 0; c < K; c++) if (ext[i+c] != m_pfx[p][c]) eq = 1'b0;
                r[p*M+i] = eq;
            end
        end
        return r;
    endfunction

    task automatic model_take(input logic [63:0] s, input bit lst);
        logic [7:0] ext [H+M];
        for (int h = 0; h < H; h++) ext[h] = m_hist[h];
        for (int j = 0; j < M; j++) ext[H+j] = s[63-8*j -: 8];
        for (int h = 0; h < H; h++) m_hist[h] = ext[M+h];
        m_cnt = lst ? 0 : H;
    endtask

    task automatic model_reset();
        for (int p = 0; p < N; p++) begin
            m_ok[p] = 1'b0;
            for (int c = 0; c < K; c++) m_pfx[p][c] = 8'h00;
        end
        for (int h = 0; h < H; h++) m_hist[h] = 8'h00;
        m_cnt = 0;
    endtask

    task automatic load_pfx(input int idx, input logic [31:0] s);
        @(negedge clk);
        wr_en  = 1'b1;
        wr_idx = idx[3:0];
        for (int c = 0; c < K; c++) begin
            wr_prefix[8*c +: 8] = s[31-8*c -: 8];
            m_pfx[idx][c] = s[31-8*c -: 8];
        end
        m_ok[idx] = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic run_beat(input logic [63:0] s, input bit v, input bit l, input string tag);
        logic [N*M-1:0] exp;
        @(negedge clk);
        stall    = 1'b0;
        in_data  = to_lanes(s);
        in_valid = v;
        in_last  = l;
        exp = v ? model_expect(s) : '0;
        if (v) model_take(s, l);
        #1 check(in_ready == 1'b1, "R8", "ready without stall", {127'b0, in_ready}, 1);
        @(posedge clk);
        #1;
        check(out_valid == v && out_last == (v & l), tag, "valid/last flags",
              {126'b0, out_valid, out_last}, {126'b0, v, v & l});
        check(out_match == exp, tag, "match matrix", out_match, exp);
        last_exp = exp;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(out_valid == 1'b0 && out_last == 1'b0, "R1", "flags in reset",
              {126'b0, out_valid, out_last}, '0);
        check(out_match == '0, "R1", "matrix in reset", out_match, '0);
        check(in_ready == 1'b1, "R1", "ready in reset", {127'b0, in_ready}, 1);
        @(negedge clk);
        rst = 1'b0;

        // R2/R9: prefixes, including a duplicate and a self-overlapping one
        load_pfx(0, "abcd");
        load_pfx(1, "cdef");
        load_pfx(2, "ghij");
        load_pfx(5, "abcd");
        load_pfx(7, "hhhh");

        // R3: table walk; each entry names its requirement
        foreach (VEC[n]) run_beat(VEC[n].txt, VEC[n].vld, VEC[n].lst, string'(VEC[n].tag));

        // R9: duplicate prefix and repeated hits in one row
        run_beat("abcdefgh", 1'b1, 1'b0, "R9");
        check(out_match[0*M+3] && out_match[5*M+3], "R9", "both abcd slots lane 3",
              out_match, last_exp);

        // R8: stall with a disruptive beat, then with no beat
        @(negedge clk);
        stall = 1'b1; in_valid = 1'b1; in_data = to_lanes("cdefcdef");
        #1 check(in_ready == 1'b0, "R8", "ready under stall", {127'b0, in_ready}, 0);
        @(posedge clk);
        #1 check(out_match == last_exp && out_valid == 1'b1, "R8", "hold under stall",
                 out_match, last_exp);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1 check(out_match == last_exp && out_valid == 1'b1, "R8", "hold, idle input",
                 out_match, last_exp);
        // R4: cross-beat ghij needs the pre-stall tail "fgh"
        run_beat("ijabcdkk", 1'b1, 1'b0, "R4");
        check(out_match[2*M+1] == 1'b1, "R4", "ghij across stall", out_match, last_exp);

        // R3: overlapping self-matches of hhhh on several lanes
        run_beat("hhhhhhhx", 1'b1, 1'b0, "R3");

        // R1/R2: reset mid-run drops every stored prefix
        @(negedge clk);
        rst = 1'b1;
        model_reset();
        @(posedge clk);
        #1 check(out_valid == 1'b0 && out_match == '0, "R1", "reset mid-run", out_match, '0);
        @(negedge clk);
        rst = 1'b0;
        run_beat("abcdefgh", 1'b1, 1'b0, "R2");
        load_pfx(3, "efgh");
        run_beat("abcdefgh", 1'b1, 1'b1, "R2");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule